// File: doc/BRIEF.md
# Serial Audio Slot Transmitter

This block drives serial audio words onto several data lanes. All lanes share one bit clock and one frame sync. Each lane has a write-only 24-bit holding register. Software writes a word into it. At the start of the next slot, the word moves automatically into that lane's shift register and then leaves the block one bit per bit-clock period. The length of the slot is chosen at run time from six values. The bit order can be most-significant first or least-significant first. An alignment control decides whether the meaningful data starts at bit 23 or at bit 15 of the written word.

The bit clock and the frame sync come from outside and are resynchronised to the system clock. A bit moves out on each falling edge of the resynchronised bit clock, and only while the frame sync is high. Once a lane's word has moved into the shift register, the lane reports that its holding register is empty. An optional interrupt request signals this. If a slot starts while a lane is still empty, that lane flags an underrun and sends its previous word again.

Top module: `audio_slot_tx`

## Requirements
- R1: After reset, every lane reports empty, no underrun is flagged, every serial output is 0, and the interrupt request is 0 while the interrupt is disabled.
- R2: Writing to a lane makes it report not-empty from the next cycle onward. The lane reports empty again once a slot start has moved its word into the shift register.
- R3: The slot length code selects the number of bits per slot: 0→8, 1→12, 2→16, 3→20, 4→24, 5→32. Codes 6 and 7 also select 32. The code and the bit order are captured at each slot start. After the last bit of a slot, the next qualified falling edge starts a new slot.
- R4: With `lsb_first`=0 the word goes out most significant bit first. With `lsb_first`=1 the same L-bit word goes out least significant bit first.
- R5: With `align16`=0 the data is taken from bit 23 downward. With `align16`=1 it is taken from bit 15 downward, and bits 23..16 are ignored. Bits below the top L valid positions are never sent.
- R6: When the slot is longer than the valid data width (24 with `align16`=0, 16 with `align16`=1), the extra bits go out as zeros.
- R7: The serial outputs change only after a falling edge of the bit clock that occurs while the frame sync is high. With the frame sync low, bit-clock edges neither start a slot nor empty a lane.
- R8: `irq` is high exactly when `irq_en` is 1 and at least one lane reports empty.
- R9: A slot start on an empty lane sets that lane's underrun flag and resends the word previously held. A write to the lane clears the flag.
- R10: Lanes hold independent data and share the slot timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Serial bit clock, asynchronous to clk |
| fsync | input | 1 | Frame sync; bits are shifted only while it is high |
| slot_sel | input | 3 | Slot length code |
| lsb_first | input | 1 | 1 selects least significant bit first |
| align16 | input | 1 | 1 takes data from bit 15 downward |
| irq_en | input | 1 | Enables the empty interrupt request |
| wr_en | input | LANES | Write strobe, one per lane |
| wr_data | input | DW | Word written to the strobed lanes |
| tx_sd | output | LANES | Serial data out, one per lane |
| tx_empty | output | LANES | Holding register empty, one per lane |
| underrun | output | LANES | Sticky underrun flag, one per lane |
| irq | output | 1 | Empty interrupt request |

## Verification
The hardest situation to reach from the ports is a slot start on a lane that is still empty. From outside it can only be recognised by comparing the resent bits with a word that was consumed a full slot earlier. The bench first lets a slot consume a word whose pattern is distinctive in least-significant-first order. It then clocks a second slot with no write in between, expects the identical bit stream together with the underrun flag, and finally writes once to watch the flag clear. A frame sync held low while the bit clock toggles is also driven, to show that a pending word stays put.

// File: rtl/audio_slot_tx.sv
module audio_slot_tx #(
  parameter int LANES = 6,
  parameter int DW    = 24,
  parameter int NW    = 16,
  parameter int SRW   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             fsync,
  input  logic [2:0]       slot_sel,
  input  logic             lsb_first,
  input  logic             align16,
  input  logic             irq_en,
  input  logic [LANES-1:0] wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [LANES-1:0] tx_sd,
  output logic [LANES-1:0] tx_empty,
  output logic [LANES-1:0] underrun,
  output logic             irq
);
  localparam int CW = $clog2(SRW + 1);

  logic [2:0]       b_sync;
  logic [1:0]       fs_sync;
  logic [CW-1:0]    cnt, len_q, len_now;
  logic             dir_q;
  logic [LANES-1:0] full, ur;
  logic [DW-1:0]    data_q [LANES];
  logic [SRW-1:0]   sr     [LANES];
  logic [SRW-1:0]   ld_word[LANES];

  wire step = b_sync[2] & ~b_sync[1] & fs_sync[1];
  wire load = step && (cnt == '0);

  always_comb begin
    case (slot_sel)
      3'd0:    len_now = CW'(8);
      3'd1:    len_now = CW'(12);
      3'd2:    len_now = CW'(16);
      3'd3:    len_now = CW'(20);
      3'd4:    len_now = CW'(24);
      default: len_now = CW'(32);
    endcase
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [SRW-1:0] frame, mask;
      frame = align16 ? (SRW'(data_q[l][NW-1:0]) << (SRW - NW))
                      : (SRW'(data_q[l]) << (SRW - DW));
      mask  = ~({SRW{1'b1}} >> len_now);
      frame = frame & mask;
      ld_word[l] = lsb_first ? (frame >> (SRW - int'(len_now))) : frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_sync  <= '0;
      fs_sync <= '0;
      cnt     <= '0;
      len_q   <= CW'(8);
      dir_q   <= 1'b0;
    end else begin
      b_sync  <= {b_sync[1:0], bclk};
      fs_sync <= {fs_sync[0], fsync};
      if (load) begin
        len_q <= len_now;
        dir_q <= lsb_first;
        cnt   <= CW'(1);
      end else if (step) begin
        cnt <= (cnt == len_q - CW'(1)) ? '0 : cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= '0;
      ur   <= '0;
      for (int l = 0; l < LANES; l++) begin
        data_q[l] <= '0;
        sr[l]     <= '0;
      end
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_en[l]) data_q[l] <= wr_data;
        if (load)      sr[l] <= ld_word[l];
        else if (step) sr[l] <= dir_q ? (sr[l] >> 1) : (sr[l] << 1);
        full[l] <= wr_en[l] ? 1'b1 : (load ? 1'b0 : full[l]);
        ur[l]   <= (load && !full[l]) ? 1'b1 : (wr_en[l] ? 1'b0 : ur[l]);
      end
    end
  end

  always_comb
    for (int l = 0; l < LANES; l++)
      tx_sd[l] = dir_q ? sr[l][0] : sr[l][SRW-1];

  assign tx_empty = ~full;
  assign underrun = ur;
  assign irq      = irq_en & |tx_empty;
endmodule

// File: rtl/audio_slot_tx_chk.sv
module audio_slot_tx_chk #(
  parameter int LANES = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             load,
  input logic             irq_en,
  input logic             irq,
  input logic [LANES-1:0] wr_en,
  input logic [LANES-1:0] tx_sd,
  input logic [LANES-1:0] tx_empty,
  input logic [LANES-1:0] underrun
);
  assert_write_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> !tx_empty[0]);

  assert_empty_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_empty[0]) |-> $past(load));

  assert_shift_only_on_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(step) |-> $stable(tx_sd));

  assert_underrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun[0]) |-> $past(load && tx_empty[0]));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
endmodule

bind audio_slot_tx audio_slot_tx_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .load(load), .irq_en(irq_en),
  .irq(irq), .wr_en(wr_en), .tx_sd(tx_sd), .tx_empty(tx_empty),
  .underrun(underrun)
);

// File: tb/audio_slot_tx_bench.sv
module audio_slot_tx_bench;
  localparam int LANES = 6;

  typedef struct packed {
    logic [2:0]  sel;
    logic        lsb;
    logic        a16;
    logic [23:0] d;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{3'd4, 1'b0, 1'b0, 24'hA5C30F, 32'hA5C30F00},
    '{3'd0, 1'b0, 1'b0, 24'h3C1234, 32'h3C000000},
    '{3'd2, 1'b0, 1'b1, 24'hFF8001, 32'h80010000},
    '{3'd5, 1'b0, 1'b0, 24'h123456, 32'h12345600},
    '{3'd1, 1'b1, 1'b0, 24'hABC000, 32'h3D500000},
    '{3'd3, 1'b0, 1'b1, 24'h00BEEF, 32'hBEEF0000},
    '{3'd2, 1'b1, 1'b0, 24'h0001FF, 32'h80000000}
  };

  logic clk = 0, rst_n = 0, bclk = 0, fsync = 0;
  logic [2:0] slot_sel = 0;
  logic lsb_first = 0, align16 = 0, irq_en = 0;
  logic [LANES-1:0] wr_en = 0;
  logic [23:0] wr_data = 0;
  logic [LANES-1:0] tx_sd, tx_empty, underrun;
  logic irq;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  audio_slot_tx #(.LANES(LANES)) u_audio_slot_tx (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
    .slot_sel(slot_sel), .lsb_first(lsb_first), .align16(align16),
    .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .tx_sd(tx_sd),
    .tx_empty(tx_empty), .underrun(underrun), .irq(irq)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input logic [2:0] s);
    case (s)
      3'd0: return 8;  3'd1: return 12; 3'd2: return 16;
      3'd3: return 20; 3'd4: return 24; default: return 32;
    endcase
  endfunction

  task automatic wr(input logic [LANES-1:0] m, input logic [23:0] d);
    wr_en = m; wr_data = d;
    wait_n(1);
    wr_en = '0;
  endtask

  task automatic run_slot(input int n, output logic [31:0] s0, output logic [31:0] s5);
    s0 = '0; s5 = '0;
    for (int i = 0; i < n; i++) begin
      bclk = 1; wait_n(8);
      bclk = 0; wait_n(6);
      s0[31-i] = tx_sd[0];
      s5[31-i] = tx_sd[LANES-1];
      wait_n(2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] s0, s5;
    logic [LANES-1:0] held;
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    chk("R1 empty", 32'(tx_empty), 32'(6'h3F));
    chk("R1 underrun", 32'(underrun), 0);
    chk("R1 tx_sd", 32'(tx_sd), 0);
    chk("R1 irq", 32'(irq), 0);

    fsync = 1;
    wait_n(4);
    for (int i = 0; i < 7; i++) begin
      slot_sel = VECS[i].sel; lsb_first = VECS[i].lsb; align16 = VECS[i].a16;
      wr('1, VECS[i].d);
      wait_n(1);
      chk("R2 full after write", 32'(tx_empty), 0);
      run_slot(len_of(VECS[i].sel), s0, s5);
      chk("R3 R4 R5 R6 lane0 stream", s0, VECS[i].exp);
      chk("R10 last lane stream", s5, VECS[i].exp);
      chk("R2 empty after slot", 32'(tx_empty), 32'(6'h3F));
    end

    run_slot(16, s0, s5);
    chk("R9 repeated word", s0, 32'h80000000);
    chk("R9 underrun set", 32'(underrun[0]), 1);
    wr(6'h01, 24'h000000);
    wait_n(1);
    chk("R9 underrun cleared", 32'(underrun[0]), 0);
    chk("R9 other lane still flagged", 32'(underrun[LANES-1]), 1);

    slot_sel = 3'd6; lsb_first = 0; align16 = 0;
    wr('1, 24'h123456);
    run_slot(32, s0, s5);
    chk("R3 code6 as 32 bits", s0, 32'h12345600);

    wr('1, 24'h777777);
    fsync = 0; wait_n(4);
    held = tx_sd;
    for (int i = 0; i < 4; i++) begin
      bclk = 1; wait_n(8); bclk = 0; wait_n(8);
    end
    chk("R7 output held with fsync low", 32'(tx_sd), 32'(held));
    chk("R7 lane stays full", 32'(tx_empty), 0);
    fsync = 1; wait_n(4);

    slot_sel = 3'd0;
    wr(6'h01, 24'hF00000);
    wr(6'h20, 24'h0F0000);
    run_slot(8, s0, s5);
    chk("R10 lane0 data", s0, 32'hF0000000);
    chk("R10 lane5 data", s5, 32'h0F000000);

    irq_en = 1; wait_n(1);
    chk("R8 irq when empty", 32'(irq), 1);
    wr('1, 24'h000001);
    wait_n(1);
    chk("R8 irq low when all full", 32'(irq), 0);
    wr('1, 24'h000002);
    wait_n(1);
    chk("R8 irq low after overwrite", 32'(irq), 0);
    irq_en = 0; wait_n(1);
    chk("R8 irq disabled", 32'(irq), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule